// File: doc/BRIEF.md
# Throttled Boot Stream SPI Master

This block is an SPI master that feeds a boot image to a slave processor. The image arrives as 32-bit words on a ready/valid interface, and every word goes out on the serial line unchanged. The image is a chain of sections. Each section opens with a three-word header: a count, then a destination address, then a type tag. The block parses these headers as they pass, so it knows where each section ends and what the next one is.

Some section types tell the slave to write a run of zeros by itself, and no data words follow their headers. The slave cannot take serial data while it writes those zeros. After such a header the block therefore waits before sending the next word. The wait is the header's count times a cycles-per-zero figure, plus a fixed guard figure. Both figures are parameters counted in system clocks. The slave can also hold the stream with an active-low feedback line. This line is synchronised and only checked between whole words, so a word that has started always finishes.

Select goes active with the first word and stays active for the whole stream. When the final section's data has been shifted out, `done` rises and no more words are requested.

Top module: `bootstrm_spi_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi` and `done` are 0.
- R2: Each word is sent as 32 bits, MSB first, in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and the rising edges inside a word are 2*CLK_DIV clocks apart.
- R3: Only one word is in flight at a time. When the next word is available and nothing pauses the stream, its first SCLK rise comes CLK_DIV+1 clocks after the last SCLK fall of the word before it.
- R4: A header is three stream words in a fixed order: count, address, tag. The tag is bits [7:0] of the third word and its upper bits are ignored. Every word, header or data, is sent unaltered.
- R5: When the tag is non-zero and not a zero-fill type, exactly `count` data words follow the header and then the next header comes. A count of 0 means the next header follows at once.
- R6: The zero-fill tags are 0x01, 0x02, 0x03, 0x07, 0x08, 0x09, 0x0A, 0x0F, 0x11, 0x17, 0x18, 0x19 and 0x1A. After one of these headers, no data words are sent. The next word's first SCLK rise is delayed by count*ZERO_CYC+GUARD_CYC clocks beyond the R3 gap.
- R7: Any other non-zero tag value, for example 0x04, 0x0E or 0x1B to 0x1F, adds no delay.
- R8: `hold_n` passes through a two-stage synchroniser. A word that has already started is finished in full. No new word starts while the synchronised line is low. If `hold_n` rises between clock edges c and c+1, the next word's first SCLK rise comes on edge c+3+CLK_DIV.
- R9: Tag 0x00 marks the final section, and its `count` data words are still sent. One clock after the last SCLK fall, `done` rises and stays high. From then on `src_ready` stays low and no further word is taken.
- R10: `spi_cs_n` goes low when the first word is accepted, SCLK rises only while it is low, and it returns high together with `done`.
- R11: When a zero-fill pause and a feedback hold are pending together, the next word starts only after both have cleared. If they clear in the same cycle, the timing is the same as for the pause alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | WORD_W | Next image word |
| src_valid | input | 1 | `src_data` holds a word |
| src_ready | output | 1 | Block takes the word at this clock edge |
| hold_n | input | 1 | Slave feedback; low holds the stream between words |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_cs_n | output | 1 | Active-low slave select |
| done | output | 1 | Final section fully sent |

## Verification
The zero-fill pause timer and the feedback hold both gate the start of the next word, so they can clear in the same cycle. The bench provokes this by lowering `hold_n` while a zero-fill header is being shifted out. It then waits for that header's last SCLK fall and raises `hold_n` early enough that the synchroniser output and the pause timer clear together. It judges the result by the exact clock of the next word's first SCLK rise, which must match the pause-only arithmetic. A separate case holds the stream longer than a data word takes, and checks that the word in flight still arrives intact and that the next rise follows the release by the synchroniser latency.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_DATA,
    ST_FINISH,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    HW_COUNT = 2'd0,
    HW_ADDR  = 2'd1,
    HW_TAG   = 2'd2
  } hdr_word_t;

  localparam logic [7:0] TAG_FINAL = 8'h00;

  // Section types whose zeros the slave writes on its own
  function automatic logic is_zero_fill(input logic [7:0] tag);
    case (tag)
      8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h09, 8'h0A,
      8'h0F, 8'h11, 8'h17, 8'h18, 8'h19, 8'h1A: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bss_hold_sync.sv
module bss_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_n,
  output logic hold_ok
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[STAGES-2:0], hold_n};
  end

  assign hold_ok = sync_q[STAGES-1];

endmodule

// File: rtl/bss_shifter.sv
module bss_shifter #(
  parameter int WORD_W  = 32,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic              busy,
  output logic              sclk,
  output logic              mosi
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, sclk_q, mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else if (load) begin
      sreg_q <= din;
      mosi_q <= din[WORD_W-1];
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_q <= 1'b0;
          end else begin
            bit_q  <= bit_q + 1'b1;
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            mosi_q <= sreg_q[WORD_W-2];
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;

endmodule

// File: rtl/bss_sequencer.sv
module bss_sequencer
  import bss_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ZERO_CYC  = 4,
  parameter int GUARD_CYC = 16,
  parameter int PAUSE_W   = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              valid,
  input  logic              hold_ok,
  input  logic              busy,
  output logic              ready,
  output logic              load,
  output logic              cs_n,
  output logic              done
);

  localparam logic [PAUSE_W-1:0] ZC = PAUSE_W'(ZERO_CYC);
  localparam logic [PAUSE_W-1:0] GC = PAUSE_W'(GUARD_CYC);

  seq_state_t         state_q;
  hdr_word_t          hw_q;
  logic [WORD_W-1:0]  count_q, rem_q;
  logic               final_q;
  logic [PAUSE_W-1:0] pause_q;
  logic               cs_n_q, done_q;
  logic               gap_open;
  logic [7:0]         tag;

  assign tag      = word[7:0];
  assign gap_open = hold_ok && !busy &&
                    ((state_q == ST_HDR && pause_q == '0) || state_q == ST_DATA);
  assign ready    = gap_open;
  assign load     = valid && gap_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HDR;
      hw_q    <= HW_COUNT;
      count_q <= '0;
      rem_q   <= '0;
      final_q <= 1'b0;
      pause_q <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      if (load) cs_n_q <= 1'b0;
      case (state_q)
        ST_HDR: begin
          if (load) begin
            case (hw_q)
              HW_COUNT: begin
                count_q <= word;
                hw_q    <= HW_ADDR;
              end
              HW_ADDR: hw_q <= HW_TAG;
              default: begin
                hw_q <= HW_COUNT;
                if (tag == TAG_FINAL) begin
                  final_q <= 1'b1;
                  rem_q   <= count_q;
                  state_q <= (count_q == '0) ? ST_FINISH : ST_DATA;
                end else if (is_zero_fill(tag)) begin
                  pause_q <= PAUSE_W'(count_q) * ZC + GC;
                end else if (count_q != '0) begin
                  rem_q   <= count_q;
                  state_q <= ST_DATA;
                end
              end
            endcase
          end else if (!busy && pause_q != '0) begin
            pause_q <= pause_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (load) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == WORD_W'(1)) state_q <= final_q ? ST_FINISH : ST_HDR;
          end
        end
        ST_FINISH: begin
          if (!busy) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
            cs_n_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_n = cs_n_q;
  assign done = done_q;

endmodule

// File: rtl/bootstrm_spi_master.sv
module bootstrm_spi_master #(
  parameter int WORD_W      = 32,
  parameter int CLK_DIV     = 4,
  parameter int ZERO_CYC    = 4,
  parameter int GUARD_CYC   = 16,
  parameter int PAUSE_W     = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              hold_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic              done
);

  logic hold_ok;
  logic busy;
  logic load;

  bss_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (hold_n),
    .hold_ok (hold_ok)
  );

  bss_sequencer #(
    .WORD_W    (WORD_W),
    .ZERO_CYC  (ZERO_CYC),
    .GUARD_CYC (GUARD_CYC),
    .PAUSE_W   (PAUSE_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .word    (src_data),
    .valid   (src_valid),
    .hold_ok (hold_ok),
    .busy    (busy),
    .ready   (src_ready),
    .load    (load),
    .cs_n    (spi_cs_n),
    .done    (done)
  );

  bss_shifter #(
    .WORD_W  (WORD_W),
    .CLK_DIV (CLK_DIV)
  ) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (src_data),
    .busy (busy),
    .sclk (spi_sclk),
    .mosi (spi_mosi)
  );

endmodule

// File: rtl/bss_checker.sv
module bss_checker (
  input logic clk,
  input logic rst,
  input logic src_valid,
  input logic src_ready,
  input logic hold_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic done
);

  // R2: data line never moves while the serial clock is high
  a_r2_mosi_steady: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> $stable(spi_mosi));

  // R3: a taken word blocks the next request for at least one cycle
  a_r3_single_word: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready) |=> !src_ready);

  // R8: a low feedback level seen two edges back blocks new words
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    !$past(hold_n, 2) |-> !src_ready);

  // R9: completion is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R9: completion leaves the line quiet
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!src_ready && spi_cs_n && !spi_sclk));

  // R10: serial clock only pulses under an active select
  a_r10_sclk_selected: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

endmodule

bind bootstrm_spi_master bss_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .hold_n    (hold_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .done      (done)
);

// File: tb/bootstrm_spi_master_tb_top.sv
module bootstrm_spi_master_tb_top;

  localparam int DIV  = 2;
  localparam int ZC   = 3;
  localparam int GC   = 5;
  localparam int NMAX = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic        hold_n = 1'b1;
  logic        spi_sclk, spi_mosi, spi_cs_n, done;

  always #10 clk = ~clk;

  bootstrm_spi_master #(
    .WORD_W(32), .CLK_DIV(DIV), .ZERO_CYC(ZC), .GUARD_CYC(GC), .PAUSE_W(40), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .hold_n(hold_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] img [NMAX];
  int          img_len = 0;
  logic [31:0] exp_w [NMAX];
  int          exp_gap [NMAX];
  string       exp_greq [NMAX];
  string       exp_wreq [NMAX];
  int          exp_len = 0;
  logic [31:0] rcv [NMAX];
  int          first_rise [NMAX];
  int          last_fall [NMAX];
  int          widx, nfall, bitcnt, last_rise;
  logic [31:0] sh;
  logic        prev_sclk;
  bit          pend_fall;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  function automatic bit zf(input int t);
    case (t)
      1, 2, 3, 7, 8, 9, 10, 15, 17, 23, 24, 25, 26: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put(input logic [31:0] w, input int gap, input string greq, input string wreq);
    exp_w[exp_len]    = w;
    exp_gap[exp_len]  = gap;
    exp_greq[exp_len] = greq;
    exp_wreq[exp_len] = wreq;
    exp_len++;
    img[img_len] = w;
    img_len++;
  endtask

  // Serial monitor, samples between clock edges
  initial begin
    widx = 0; nfall = 0; bitcnt = 0; pend_fall = 0; prev_sclk = 0; sh = '0; last_rise = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        widx = 0; nfall = 0; bitcnt = 0; pend_fall = 0; prev_sclk = 0;
      end else begin
        if (spi_sclk && !prev_sclk) begin
          if (spi_cs_n) check(1'b0, "R10 sclk rose with select high", 1, 0);
          if (bitcnt == 0) first_rise[widx] = cyc;
          else check(cyc - last_rise == 2 * DIV, "R2 bit period", cyc - last_rise, 2 * DIV);
          last_rise = cyc;
          sh = {sh[30:0], spi_mosi};
          bitcnt++;
          if (bitcnt == 32) begin
            rcv[widx] = sh;
            widx++;
            bitcnt = 0;
            pend_fall = 1;
          end
        end else if (!spi_sclk && prev_sclk && pend_fall) begin
          last_fall[widx-1] = cyc;
          nfall++;
          pend_fall = 0;
        end
        prev_sclk = spi_sclk;
      end
    end
  end

  // Word source
  initial begin
    int idx;
    bit pend;
    idx = 0; pend = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        idx = 0; pend = 0;
      end else if (pend) begin
        idx++;
      end
      src_valid = (idx < img_len);
      src_data  = src_valid ? img[idx] : 32'h0;
      pend      = src_valid && src_ready && !rst;
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  task automatic compare_run(input bit check_gaps);
    check(widx == exp_len, "R9 word total", widx, exp_len);
    for (int k = 0; k < exp_len; k++) begin
      check(rcv[k] == exp_w[k], exp_wreq[k], rcv[k], exp_w[k]);
      if (check_gaps && k > 0)
        check(first_rise[k] - last_fall[k-1] == exp_gap[k], exp_greq[k],
              first_rise[k] - last_fall[k-1], exp_gap[k]);
    end
  endtask

  task automatic finish_run;
    wait (nfall == exp_len);
    check(done == 1'b0, "R9 done not early", done, 0);
    tick();
    check(done == 1'b1, "R9 done after last fall", done, 1);
    check(spi_cs_n == 1'b1, "R10 select released", spi_cs_n, 1);
    repeat (40) tick();
    check(src_ready == 1'b0, "R9 no request after done", src_ready, 0);
    check(widx == exp_len && !spi_sclk, "R9 trailing word not sent", widx, exp_len);
  endtask

  initial begin
    int extra;
    int c;
    int f;
    int rel;
    // ---------- run 1: sweep over every tag 0x01..0x1F ----------
    extra = 0;
    for (int t = 1; t < 32; t++) begin
      c = t % 4;
      put(32'(c), DIV + 1 + extra, (extra != 0) ? "R6 zero-fill pause" : "R3 spacing", "R4 header count");
      extra = 0;
      put(32'h0001_0000 + 32'(t), DIV + 1, "R3 spacing", "R4 header address");
      put(32'h5A00_0000 | 32'(t), DIV + 1, "R3 spacing", "R4 header tag");
      if (zf(t)) begin
        extra = c * ZC + GC;
      end else begin
        for (int i = 0; i < c; i++)
          put({8'(t), 8'(i), 16'hC3A5}, DIV + 1, (i == 0) ? "R7 no pause" : "R5 data spacing", "R5 data word");
      end
    end
    put(32'd2, DIV + 1 + extra, "R6 zero-fill pause", "R4 final count");
    put(32'h0004_0100, DIV + 1, "R3 spacing", "R4 final address");
    put(32'h5A00_0000, DIV + 1, "R3 spacing", "R9 final tag");
    put(32'h8000_0001, DIV + 1, "R9 final data spacing", "R9 final data");
    put(32'h7FFF_FFFE, DIV + 1, "R9 final data spacing", "R9 final data");
    img[img_len] = 32'hDEAD_BEEF;
    img_len++;

    repeat (3) tick();
    check(spi_cs_n == 1'b1, "R1 select idle", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
    check(spi_mosi == 1'b0, "R1 mosi idle", spi_mosi, 0);
    check(done == 1'b0, "R1 done idle", done, 0);
    rst = 1'b0;
    check(spi_cs_n == 1'b1 && done == 1'b0, "R1 first cycle", spi_cs_n, 1);
    wait (widx == 1);
    check(spi_cs_n == 1'b0, "R10 select active", spi_cs_n, 0);
    finish_run();
    compare_run(1'b1);

    // ---------- run 2: feedback hold and coincidence ----------
    tick();
    rst = 1'b1;
    img_len = 0;
    exp_len = 0;
    put(32'd2, 0, "", "R4 count");
    put(32'h0000_2000, 0, "", "R4 address");
    put(32'h0000_0004, 0, "", "R4 tag");
    put(32'hA5A5_0F0F, 0, "", "R8 word in flight intact");
    put(32'h1234_5678, 0, "", "R5 data");
    put(32'd4, 0, "", "R4 count");
    put(32'h0000_3000, 0, "", "R4 address");
    put(32'h0000_0002, 0, "", "R6 zero-fill tag");
    put(32'd1, 0, "", "R4 count");
    put(32'h0000_4000, 0, "", "R4 address");
    put(32'h0000_0000, 0, "", "R9 final tag");
    put(32'hCAFE_F00D, 0, "", "R9 final data");
    repeat (4) tick();
    rst = 1'b0;

    wait (widx == 3 && bitcnt >= 1);
    tick();
    hold_n = 1'b0;
    repeat (150) tick();
    hold_n = 1'b1;
    rel = cyc;
    wait (widx == 7 && bitcnt >= 1);
    check(first_rise[4] == rel + 3 + DIV, "R8 resume after hold", first_rise[4], rel + 3 + DIV);
    tick();
    hold_n = 1'b0;
    wait (nfall == 8);
    f = last_fall[7];
    repeat (4 * ZC + GC - 2) tick();
    hold_n = 1'b1;
    wait (widx == 9);
    check(first_rise[8] == f + 4 * ZC + GC + 1 + DIV, "R11 hold and pause clear together",
          first_rise[8], f + 4 * ZC + GC + 1 + DIV);
    finish_run();
    compare_run(1'b0);

    finished = 1;
    summary();
    $finish;
  end

endmodule